// File: doc/BRIEF.md
# Two-Channel Serial Peripheral Byte Mover

This block moves bytes between one serial peripheral and system memory with no help from the processor. It has two channels. The receive channel takes bytes that the peripheral offers and writes them to memory. The transmit channel reads bytes from memory and hands them to the peripheral. Each channel keeps its own 32-bit byte address and its own 16-bit remaining-byte counter. Software sets both through a small register port.

The peripheral raises a request for each byte. The block answers with an acknowledge pulse once the matching memory access has completed. It drives a single-beat memory master port and allows only one access in flight at a time. When both channels want the memory in the same idle cycle, the receive side goes first, so incoming data is not overrun.

When a channel's counter runs down to zero, the channel stops and raises a level end flag. The peripheral's interrupt logic can use that flag. Writing a fresh nonzero count clears the flag and starts the channel again.

Top module: `perdma_pair`

## Requirements
- R1: After reset, both pointers and both counts read zero, both end flags are low and `mem_req` is low.
- R2: A receive grant writes the offered `rx_data` byte to memory at the receive pointer, with `mem_we` high.
- R3: Each completed byte adds one to the channel's pointer (modulo 2^32) and subtracts one from its count.
- R4: A channel's end flag goes high in the cycle its count reaches zero through a completed byte, and it stays high.
- R5: There is exactly one acknowledge for each completed access, in the cycle `mem_done` is seen. Only one access is outstanding at a time, and `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_done`.
- R6: While a channel's count is zero, its peripheral requests are ignored: no memory access, no acknowledge.
- R7: A transmit grant reads memory at the transmit pointer with `mem_we` low. The returned byte appears on `tx_data` together with `tx_ack`.
- R8: Writing a nonzero count clears that channel's end flag and re-arms the channel. The other channel's flag is not affected.
- R9: When both channels are eligible in the same idle cycle, the receive channel is granted first.
- R10: Register map: `reg_addr[1]` selects the channel (0 receive, 1 transmit) and `reg_addr[0]` selects pointer (0) or count (1). The count reads zero-extended. Reads return the live value, including during a transfer.
- R11: The full 16-bit count range is accepted: a count of 0xFFFF reads back as 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: bit 1 channel, bit 0 pointer/count |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Live read data of the selected register |
| rx_req | input | 1 | Peripheral has a received byte |
| rx_data | input | DW | Received byte, held until acknowledged |
| rx_ack | output | 1 | Received byte stored in memory |
| tx_req | input | 1 | Peripheral wants a byte to send |
| tx_ack | output | 1 | Transmit byte valid on `tx_data` |
| tx_data | output | DW | Byte read for the peripheral |
| rx_end | output | 1 | Receive count exhausted |
| tx_end | output | 1 | Transmit count exhausted |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write byte |
| mem_rdata | input | DW | Read byte, valid with `mem_done` |
| mem_done | input | 1 | Access completes this cycle |

## Verification
The bench uses the default widths: 32-bit pointers, 16-bit counts and 8-bit data. This makes pointer wrap from 0xFFFFFFFF to zero and the largest count of 0xFFFF directly testable. A bench memory with an adjustable wait-state count stretches accesses over several cycles. That lets the live readback and the hold-until-done rule be seen while an access is in flight. Priority is exercised by raising both requests in the same cycle and logging the order of the completed accesses.

// File: rtl/perdma_pkg.sv
package perdma_pkg;
    typedef enum logic {
        SEL_RX = 1'b0,
        SEL_TX = 1'b1
    } chan_e;

    localparam int NCHAN   = 2;
    localparam int RX_IDX  = 0;
    localparam int TX_IDX  = 1;
    localparam int FLD_CNT = 1;   // reg_addr[0] = 1 selects count
endpackage

// File: rtl/perdma_chan.sv
module perdma_chan #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ptr,
    input  logic          wr_cnt,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic          fin,
    output logic          live
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          fin;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step && st_q.cnt != '0) begin
            st_d.ptr = st_q.ptr + 1'b1;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) st_d.fin = 1'b1;
        end
        if (wr_ptr) st_d.ptr = wdata;
        if (wr_cnt) begin
            st_d.cnt = wdata[CW-1:0];
            if (wdata[CW-1:0] != '0) st_d.fin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr  = st_q.ptr;
    assign cnt  = st_q.cnt;
    assign fin  = st_q.fin;
    assign live = (st_q.cnt != '0);
endmodule

// File: rtl/perdma_eng.sv
module perdma_eng
    import perdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_want,
    input  logic          tx_want,
    input  logic [AW-1:0] rx_ptr,
    input  logic [AW-1:0] tx_ptr,
    input  logic [DW-1:0] rx_byte,
    input  logic          mem_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rx_step,
    output logic          tx_step
);
    typedef struct packed {
        logic          busy;
        chan_e         sel;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (rx_want) begin
                st_d.busy  = 1'b1;
                st_d.sel   = SEL_RX;
                st_d.addr  = rx_ptr;
                st_d.wdata = rx_byte;
            end else if (tx_want) begin
                st_d.busy  = 1'b1;
                st_d.sel   = SEL_TX;
                st_d.addr  = tx_ptr;
                st_d.wdata = '0;
            end
        end else if (mem_done) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, sel: SEL_RX, addr: '0, wdata: '0};
        else        st_q <= st_d;
    end

    assign mem_req   = st_q.busy;
    assign mem_we    = (st_q.sel == SEL_RX);
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign rx_step   = st_q.busy && mem_done && (st_q.sel == SEL_RX);
    assign tx_step   = st_q.busy && mem_done && (st_q.sel == SEL_TX);
endmodule

// File: rtl/perdma_pair.sv
module perdma_pair
    import perdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          rx_req,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ack,
    input  logic          tx_req,
    output logic          tx_ack,
    output logic [DW-1:0] tx_data,
    output logic          rx_end,
    output logic          tx_end,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done
);
    localparam int PADW = AW - CW;

    logic [AW-1:0] ptr_w  [NCHAN];
    logic [CW-1:0] cnt_w  [NCHAN];
    logic          fin_w  [NCHAN];
    logic          live_w [NCHAN];
    logic          step_w [NCHAN];
    logic          req_w  [NCHAN];

    assign req_w[RX_IDX] = rx_req;
    assign req_w[TX_IDX] = tx_req;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic hit;
        assign hit = reg_we && (reg_addr[1] == c[0]);
        perdma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ptr (hit && (reg_addr[0] != FLD_CNT[0])),
            .wr_cnt (hit && (reg_addr[0] == FLD_CNT[0])),
            .wdata  (reg_wdata),
            .step   (step_w[c]),
            .ptr    (ptr_w[c]),
            .cnt    (cnt_w[c]),
            .fin    (fin_w[c]),
            .live   (live_w[c])
        );
    end

    perdma_eng #(.AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_want   (req_w[RX_IDX] && live_w[RX_IDX]),
        .tx_want   (req_w[TX_IDX] && live_w[TX_IDX]),
        .rx_ptr    (ptr_w[RX_IDX]),
        .tx_ptr    (ptr_w[TX_IDX]),
        .rx_byte   (rx_data),
        .mem_done  (mem_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rx_step   (step_w[RX_IDX]),
        .tx_step   (step_w[TX_IDX])
    );

    always_comb begin
        if (reg_addr[0] == FLD_CNT[0])
            reg_rdata = {{PADW{1'b0}}, cnt_w[reg_addr[1]]};
        else
            reg_rdata = ptr_w[reg_addr[1]];
    end

    assign rx_ack  = step_w[RX_IDX];
    assign tx_ack  = step_w[TX_IDX];
    assign tx_data = mem_rdata;
    assign rx_end  = fin_w[RX_IDX];
    assign tx_end  = fin_w[TX_IDX];
endmodule

// File: rtl/perdma_pair_chk.sv
module perdma_pair_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          rx_req,
    input logic          rx_ack,
    input logic          tx_ack,
    input logic          rx_end,
    input logic          tx_end,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_done,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt
);
    assert_ack_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack || tx_ack) |-> (mem_req && mem_done));

    assert_one_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ack && tx_ack));

    assert_hold_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_rx_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && rx_req && rx_cnt != '0) |=> (mem_req && mem_we));

    assert_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && rx_cnt == '0 && tx_cnt == '0) |=> !mem_req);

    assert_rx_end_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_end) |-> (rx_cnt == '0));

    assert_tx_end_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> (tx_cnt == '0));

    assert_rx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !reg_we) |=> (rx_cnt == $past(rx_cnt) - CW'(1)));
endmodule

bind perdma_pair perdma_pair_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .rx_req   (rx_req),
    .rx_ack   (rx_ack),
    .tx_ack   (tx_ack),
    .rx_end   (rx_end),
    .tx_end   (tx_end),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_done (mem_done),
    .rx_cnt   (cnt_w[0]),
    .tx_cnt   (cnt_w[1])
);

// File: tb/perdma_pair_test.sv
module perdma_pair_test;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          rx_req = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_ack;
    logic          tx_req = 1'b0;
    logic          tx_ack;
    logic [DW-1:0] tx_data;
    logic          rx_end, tx_end;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_done = 1'b0;

    perdma_pair #(.AW(AW), .CW(CW), .DW(DW)) uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [256];
    int rx_left = 0, tx_left = 0, rx_idx = 0, tx_idx = 0;
    int rx_acks = 0, tx_acks = 0, req_cycles = 0, lat = 0, wait_ctr = 0;
    logic [7:0] rx_base = '0;
    logic [7:0] tx_buf [16];
    logic ord [16];
    int n_ord = 0;
    logic pend = 0, pend_we = 0, pend_rx = 0, pend_tx = 0;
    logic [7:0] pend_addr = '0, pend_wdata = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // memory and peripheral model, all driven at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin
                pend = 0;
                if (pend_we) mem[pend_addr] = pend_wdata;
                if (pend_rx) begin rx_acks++; rx_left--; rx_idx++; end
                if (pend_tx) begin tx_acks++; tx_left--; tx_idx++; end
            end
            mem_done = 1'b0;
            if (mem_req) begin
                req_cycles++;
                if (wait_ctr >= lat) begin
                    wait_ctr   = 0;
                    mem_done   = 1'b1;
                    mem_rdata  = mem[mem_addr[7:0]];
                    pend       = 1;
                    pend_we    = mem_we;
                    pend_addr  = mem_addr[7:0];
                    pend_wdata = mem_wdata;
                    if (n_ord < 16) begin ord[n_ord] = mem_we; n_ord++; end
                    #1;
                    pend_rx = rx_ack;
                    pend_tx = tx_ack;
                    if (tx_ack && tx_idx < 16) tx_buf[tx_idx] = tx_data;
                end else begin
                    wait_ctr++;
                end
            end
            rx_req  = (rx_left > 0);
            rx_data = rx_base + 8'(rx_idx);
            tx_req  = (tx_left > 0);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk); #3;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((rx_left != 0 || tx_left != 0 || mem_req || pend) && n < 2000) begin
            @(negedge clk); #3; n++;
        end
        @(negedge clk); #3;
        check(n < 2000, "R5 transfer completes", 32'(n), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1 register zero after reset", v, 0);
        end
        check(!rx_end && !tx_end && !mem_req, "R1 flags and request low",
              {rx_end, tx_end, mem_req}, 0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] v;
        lat = 1;
        wr(2'b00, 32'h10); wr(2'b01, 32'd4);
        rx_base = 8'hA0; rx_idx = 0; rx_acks = 0;
        @(posedge clk); #2; rx_left = 4;
        wait_idle();
        for (int i = 0; i < 4; i++)
            check(mem[8'h10 + 8'(i)] == 8'hA0 + 8'(i), "R2 received byte stored",
                  mem[8'h10 + 8'(i)], 8'hA0 + 8'(i));
        check(rx_acks == 4, "R5 one ack per byte", rx_acks, 4);
        rd(2'b00, v); check(v == 32'h14, "R3 rx pointer advanced", v, 32'h14);
        rd(2'b01, v); check(v == 0, "R3 rx count exhausted", v, 0);
        check(rx_end == 1'b1, "R4 rx end flag", rx_end, 1);
        check(tx_end == 1'b0, "R4 tx end untouched", tx_end, 0);
    endtask

    task automatic t_ignore();
        req_cycles = 0;
        rx_acks = 0;
        mem[8'h14] = 8'h5A;
        @(posedge clk); #2; rx_left = 2;
        repeat (30) @(negedge clk);
        #3;
        check(req_cycles == 0, "R6 no access at zero count", req_cycles, 0);
        check(rx_acks == 0, "R6 no ack at zero count", rx_acks, 0);
        check(mem[8'h14] == 8'h5A, "R6 memory untouched", mem[8'h14], 8'h5A);
        check(rx_end == 1'b1, "R6 end flag held", rx_end, 1);
        @(posedge clk); #2; rx_left = 0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_tx_basic();
        logic [31:0] v;
        mem[8'h40] = 8'h05; mem[8'h41] = 8'h06; mem[8'h42] = 8'h07;
        lat = 0;
        wr(2'b10, 32'h40); wr(2'b11, 32'd3);
        tx_idx = 0; tx_acks = 0;
        @(posedge clk); #2; tx_left = 3;
        wait_idle();
        for (int i = 0; i < 3; i++)
            check(tx_buf[i] == 8'h05 + 8'(i), "R7 transmit byte delivered",
                  tx_buf[i], 8'h05 + 8'(i));
        rd(2'b10, v); check(v == 32'h43, "R3 tx pointer advanced", v, 32'h43);
        check(tx_end == 1'b1, "R4 tx end flag", tx_end, 1);
    endtask

    task automatic t_rearm();
        wr(2'b01, 32'd2);
        @(negedge clk); #3;
        check(rx_end == 1'b0, "R8 nonzero count clears end", rx_end, 0);
        check(tx_end == 1'b1, "R8 other flag kept", tx_end, 1);
        wr(2'b01, 32'd0);
        @(negedge clk); #3;
        check(rx_end == 1'b0, "R8 zero count leaves flag", rx_end, 0);
    endtask

    task automatic t_priority();
        wr(2'b00, 32'h80); wr(2'b01, 32'd2);
        wr(2'b10, 32'h40); wr(2'b11, 32'd2);
        n_ord = 0; rx_idx = 0; tx_idx = 0; rx_base = 8'h30; lat = 0;
        @(posedge clk); #2; rx_left = 2; tx_left = 2;
        wait_idle();
        check(n_ord == 4, "R9 four accesses", n_ord, 4);
        check(ord[0] && ord[1] && !ord[2] && !ord[3], "R9 receive served first",
              {28'd0, ord[0], ord[1], ord[2], ord[3]}, 32'hC);
        check(mem[8'h81] == 8'h31, "R2 second receive byte", mem[8'h81], 8'h31);
    endtask

    task automatic t_live();
        logic [31:0] v;
        int n = 0;
        lat = 4;
        wr(2'b00, 32'hC0); wr(2'b01, 32'd3);
        rx_acks = 0; rx_idx = 0; rx_base = 8'h11;
        @(posedge clk); #2; rx_left = 3;
        while (rx_acks < 1 && n < 200) begin @(negedge clk); #3; n++; end
        check(mem_req == 1'b0, "R10 between accesses", mem_req, 0);
        v = reg_rdata;
        reg_addr = 2'b01;
        #1; v = reg_rdata;
        check(v == 32'd2, "R10 live count mid-transfer", v, 2);
        reg_addr = 2'b00;
        #1; v = reg_rdata;
        check(v == 32'hC1, "R10 live pointer mid-transfer", v, 32'hC1);
        wait_idle();
        rd(2'b01, v); check(v == 0, "R10 count after transfer", v, 0);
    endtask

    task automatic t_limits();
        logic [31:0] v;
        lat = 0;
        wr(2'b01, 32'h0000_FFFF);
        rd(2'b01, v); check(v == 32'hFFFF, "R11 full count range", v, 32'hFFFF);
        check(rx_end == 1'b0, "R11 armed at full count", rx_end, 0);
        wr(2'b01, 32'd1);
        wr(2'b00, 32'hFFFF_FFFF);
        rx_idx = 0; rx_base = 8'hEE;
        @(posedge clk); #2; rx_left = 1;
        wait_idle();
        check(mem[8'hFF] == 8'hEE, "R2 byte at top address", mem[8'hFF], 8'hEE);
        rd(2'b00, v); check(v == 0, "R3 pointer wraps to zero", v, 0);
        check(rx_end == 1'b1, "R4 end after single byte", rx_end, 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        t_reset();
        t_rx_basic();
        t_ignore();
        t_tx_basic();
        t_rearm();
        t_priority();
        t_live();
        t_limits();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule